// File: doc/BRIEF.md
# Flash command sequence decoder

This block watches the write cycles that a host issues to a byte-wide parallel flash and turns well-formed unlock sequences into single-cycle operation requests for the array engine. Each write presents a full byte address and a data byte. The low 12 address bits, together with the data, are matched against the expected unlock pattern. The supported operations are byte program, user security-ID byte program, sector erase, block erase, chip erase, erase suspend and erase resume. The block also keeps a read-mode register that selects between the array, the identification codes, the query table and the security-ID space.

The array engine reports the end of each internal operation with a one-cycle `op_done_i` pulse. While a program or erase runs, every write is ignored except a suspend byte during a sector or block erase. While an erase is suspended, the host may program any byte outside the suspended sector or block and may then resume the erase. When write-protect is low, the 64 KB boot block cannot be erased and chip erase is refused. A parameter places the boot block at the top or the bottom of the space.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AAh@AAAh, 55h@555h, A0h@AAAh (low 12 address bits compared), followed by any write, issue op_kind 1 (program) with that write's address and data. op_valid_o is high during the cycle after the clock edge that samples the final write.
- R2: The same prefix with a third code of A5h issues op_kind 2 (security-ID program) with the next write's address and data.
- R3: Third code 80h, then AAh@AAAh, then 55h@555h, then a sixth write issues an erase. 10h@AAAh gives op_kind 5 (chip). 50h gives op_kind 3 (sector), and 30h gives op_kind 4 (block), each carrying the sixth write's address.
- R4: The mode is a 2-bit code: 0 array, 1 ID, 2 query, 3 security ID. A third code of 90h, 98h or 88h sets 1, 2 or 3. A third code of F0h, or a single F0h write at any address, sets 0.
- R5: In mode 1, rd_addr_i = 0 gives id_data_o = BFh and rd_addr_i = 1 gives the device-code parameter (default C9h). Any other address or mode gives 00h.
- R6: A write that breaks a sequence (wrong address or data at any step) issues nothing and sets the mode to 0. A stray write in idle that matches no command changes nothing.
- R7: While busy_o is high (program, erase, or program during suspend), writes issue nothing and leave the mode unchanged, the F0h exit included. op_done_i clears busy_o.
- R8: With wp_ni low, chip erase and any sector or block erase whose address bits 20..16 equal the boot block (all ones when TOP_BOOT=1) are dropped, and busy_o stays low.
- R9: During a sector or block erase, a single B0h write issues op_kind 6, raises suspended_o and lowers busy_o. While suspended, a single 30h write issues op_kind 7 and the erase continues (busy_o high). B0h during chip erase is ignored.
- R10: While suspended, a program whose target shares the suspended sector (bits 20..12) or block (bits 20..16) is discarded. Any other program is issued, and its op_done_i returns the block to the suspended state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one cycle per bus write |
| addr_i | input | 21 | Write byte address |
| data_i | input | 8 | Write data byte |
| wp_ni | input | 1 | Boot-block write protect, active low |
| op_done_i | input | 1 | Array engine finished the running operation |
| rd_addr_i | input | 21 | Read address for identification codes |
| op_valid_o | output | 1 | Operation request strobe |
| op_kind_o | output | 3 | Request kind (1..7, see R1-R3, R9) |
| op_addr_o | output | 21 | Target address of the request |
| op_data_o | output | 8 | Data of the request |
| mode_o | output | 2 | Read-mode code |
| busy_o | output | 1 | Internal program or erase running |
| suspended_o | output | 1 | An erase is suspended |
| id_data_o | output | 8 | Identification byte for rd_addr_i |

## Verification
A sequence state left behind by an aborted or ignored write shows up at the very next write. A later valid command either fails to issue or issues one cycle too early, so each sequence is checked on op_valid_o in the cycle right after its last write. A wrong run state shows up on busy_o and suspended_o in the cycle after the edge that causes it. It also shows up as a suspend, resume or program that is refused or accepted wrongly on the next single-byte write. Protect gating is checked as a missing or extra request, under directed cases and random erase targets with a random write-protect level.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned CMD_AW = 12;

  localparam logic [CMD_AW-1:0] ADDR_A = 12'hAAA;
  localparam logic [CMD_AW-1:0] ADDR_B = 12'h555;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_SPROG   = 8'hA5;
  localparam logic [7:0] D_ERASE   = 8'h80;
  localparam logic [7:0] D_ID      = 8'h90;
  localparam logic [7:0] D_CFI     = 8'h98;
  localparam logic [7:0] D_SECID   = 8'h88;
  localparam logic [7:0] D_EXIT    = 8'hF0;
  localparam logic [7:0] D_SUSP    = 8'hB0;
  localparam logic [7:0] D_RESUME  = 8'h30;
  localparam logic [7:0] D_CHIP    = 8'h10;
  localparam logic [7:0] D_SECT    = 8'h50;
  localparam logic [7:0] D_BLK     = 8'h30;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_SPROG = 3'd2, OP_SECT = 3'd3,
    OP_BLK  = 3'd4, OP_CHIP = 3'd5, OP_SUSP  = 3'd6, OP_RESUME = 3'd7
  } op_kind_e;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0, MODE_ID = 2'd1, MODE_CFI = 2'd2, MODE_SECID = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    C_NONE, C_PROG, C_SPROG, C_SECT, C_BLK, C_CHIP, C_SUSP, C_RESUME,
    C_ID, C_CFI, C_SECID, C_EXIT, C_ABORT
  } cmd_e;
endpackage

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CMD_AW-1:0] addr_lo_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  output cmd_e              cmd_o
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_SPGM, S_E3, S_E4, S_E5} seq_e;

  seq_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (addr_lo_i == ADDR_A);
  assign at_b = (addr_lo_i == ADDR_B);

  always_comb begin
    st_d  = st_q;
    cmd_o = C_NONE;
    if (busy_i) begin
      st_d = S_IDLE;
      if (wr_i && data_i == D_SUSP) cmd_o = C_SUSP;
    end else if (wr_i) begin
      unique case (st_q)
        S_IDLE: begin
          if (at_a && data_i == D_KEY1) st_d = S_U1;
          else if (data_i == D_EXIT)    cmd_o = C_EXIT;
          else if (data_i == D_SUSP)    cmd_o = C_SUSP;
          else if (data_i == D_RESUME)  cmd_o = C_RESUME;
        end
        S_U1: begin
          if (at_b && data_i == D_KEY2) st_d = S_U2;
          else begin st_d = S_IDLE; cmd_o = C_ABORT; end
        end
        S_U2: begin
          st_d = S_IDLE;
          if (!at_a) cmd_o = C_ABORT;
          else begin
            case (data_i)
              D_PROG:  st_d = S_PGM;
              D_SPROG: st_d = S_SPGM;
              D_ERASE: st_d = S_E3;
              D_ID:    cmd_o = C_ID;
              D_CFI:   cmd_o = C_CFI;
              D_SECID: cmd_o = C_SECID;
              D_EXIT:  cmd_o = C_EXIT;
              default: cmd_o = C_ABORT;
            endcase
          end
        end
        S_PGM:  begin st_d = S_IDLE; cmd_o = C_PROG;  end
        S_SPGM: begin st_d = S_IDLE; cmd_o = C_SPROG; end
        S_E3: begin
          if (at_a && data_i == D_KEY1) st_d = S_E4;
          else begin st_d = S_IDLE; cmd_o = C_ABORT; end
        end
        S_E4: begin
          if (at_b && data_i == D_KEY2) st_d = S_E5;
          else begin st_d = S_IDLE; cmd_o = C_ABORT; end
        end
        S_E5: begin
          st_d = S_IDLE;
          if (at_a && data_i == D_CHIP) cmd_o = C_CHIP;
          else if (data_i == D_SECT)    cmd_o = C_SECT;
          else if (data_i == D_BLK)     cmd_o = C_BLK;
          else                          cmd_o = C_ABORT;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  // R7: a busy cycle always leaves the sequencer idle
  a_r7_seq_idle_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (st_q == S_IDLE));
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 21,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned BLK_LSB  = 16,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          wp_ni,
  input  logic          op_done_i,
  output logic          op_valid_o,
  output op_kind_e      op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output mode_e         mode_o,
  output logic          busy_o,
  output logic          susp_o
);
  localparam int unsigned BW = AW - BLK_LSB;
  localparam int unsigned SW = AW - SECT_LSB;

  typedef enum logic [2:0] {R_IDLE, R_PROG, R_ERASE, R_SUSP, R_SPROG} run_e;

  run_e          run_q, run_d;
  op_kind_e      er_kind_q, er_kind_d;
  logic [AW-1:0] er_addr_q, er_addr_d;
  mode_e         mode_q, mode_d;
  logic          op_valid_q, issue;
  op_kind_e      op_kind_q, kind_d;
  logic [AW-1:0] op_addr_q, oaddr_d;
  logic [7:0]    op_data_q;
  logic [BW-1:0] prot_blk;
  logic          hit_prot, same_sect, same_blk, in_region, erase_ok;

  generate
    if (TOP_BOOT) begin : g_top_boot
      assign prot_blk = '1;
    end else begin : g_bottom_boot
      assign prot_blk = '0;
    end
  endgenerate

  assign hit_prot  = (addr_i[AW-1:BLK_LSB] == prot_blk);
  assign same_sect = (addr_i[AW-1:SECT_LSB] == er_addr_q[AW-1:SECT_LSB]);
  assign same_blk  = (addr_i[AW-1:BLK_LSB] == er_addr_q[AW-1:BLK_LSB]);
  assign in_region = (er_kind_q == OP_SECT) ? same_sect : same_blk;
  assign erase_ok  = wp_ni || !hit_prot;

  always_comb begin
    run_d     = run_q;
    er_kind_d = er_kind_q;
    er_addr_d = er_addr_q;
    issue     = 1'b0;
    kind_d    = OP_NONE;
    oaddr_d   = addr_i;
    unique case (run_q)
      R_IDLE: begin
        unique case (cmd_i)
          C_PROG:  begin issue = 1'b1; kind_d = OP_PROG;  run_d = R_PROG; end
          C_SPROG: begin issue = 1'b1; kind_d = OP_SPROG; run_d = R_PROG; end
          C_SECT, C_BLK: if (erase_ok) begin
            issue     = 1'b1;
            kind_d    = (cmd_i == C_SECT) ? OP_SECT : OP_BLK;
            run_d     = R_ERASE;
            er_kind_d = kind_d;
            er_addr_d = addr_i;
          end
          C_CHIP: if (wp_ni) begin
            issue = 1'b1; kind_d = OP_CHIP; run_d = R_ERASE;
            er_kind_d = OP_CHIP; er_addr_d = addr_i;
          end
          default: ;
        endcase
      end
      R_PROG: if (op_done_i) run_d = R_IDLE;
      R_ERASE: begin
        if (op_done_i) run_d = R_IDLE;
        else if (cmd_i == C_SUSP && er_kind_q != OP_CHIP) begin
          issue = 1'b1; kind_d = OP_SUSP; oaddr_d = er_addr_q; run_d = R_SUSP;
        end
      end
      R_SUSP: begin
        unique case (cmd_i)
          C_RESUME: begin issue = 1'b1; kind_d = OP_RESUME; oaddr_d = er_addr_q; run_d = R_ERASE; end
          C_PROG:   if (!in_region) begin issue = 1'b1; kind_d = OP_PROG; run_d = R_SPROG; end
          C_SPROG:  begin issue = 1'b1; kind_d = OP_SPROG; run_d = R_SPROG; end
          default: ;
        endcase
      end
      R_SPROG: if (op_done_i) run_d = R_SUSP;
      default: run_d = R_IDLE;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    unique case (cmd_i)
      C_ID:             mode_d = MODE_ID;
      C_CFI:            mode_d = MODE_CFI;
      C_SECID:          mode_d = MODE_SECID;
      C_EXIT, C_ABORT:  mode_d = MODE_ARRAY;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= R_IDLE;
      er_kind_q  <= OP_NONE;
      er_addr_q  <= '0;
      mode_q     <= MODE_ARRAY;
      op_valid_q <= 1'b0;
      op_kind_q  <= OP_NONE;
      op_addr_q  <= '0;
      op_data_q  <= '0;
    end else begin
      run_q      <= run_d;
      er_kind_q  <= er_kind_d;
      er_addr_q  <= er_addr_d;
      mode_q     <= mode_d;
      op_valid_q <= issue;
      if (issue) begin
        op_kind_q <= kind_d;
        op_addr_q <= oaddr_d;
        op_data_q <= data_i;
      end
    end
  end

  assign op_valid_o = op_valid_q;
  assign op_kind_o  = op_kind_q;
  assign op_addr_o  = op_addr_q;
  assign op_data_o  = op_data_q;
  assign mode_o     = mode_q;
  assign busy_o     = (run_q == R_PROG) || (run_q == R_ERASE) || (run_q == R_SPROG);
  assign susp_o     = (run_q == R_SUSP) || (run_q == R_SPROG);

  // R7: nothing is requested while a program runs
  a_r7_quiet_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == R_PROG || run_q == R_SPROG) |=> !op_valid_q);
  // R7: mode frozen while busy
  a_r7_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q));
  // R8: protected erases need write-protect released
  a_r8_chip_needs_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_q && op_kind_q == OP_CHIP) |-> $past(wp_ni));
  a_r8_boot_needs_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_q && (op_kind_q == OP_SECT || op_kind_q == OP_BLK)
     && op_addr_q[AW-1:BLK_LSB] == prot_blk) |-> $past(wp_ni));
  // R9: resume only from suspend
  a_r9_resume_from_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_q && op_kind_q == OP_RESUME) |-> ($past(run_q) == R_SUSP));
  // R10: suspended region never programmed
  a_r10_no_prog_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_q && op_kind_q == OP_PROG && $past(run_q) == R_SUSP && er_kind_q == OP_SECT)
    |-> (op_addr_q[AW-1:SECT_LSB] != er_addr_q[AW-1:SECT_LSB]));

  logic [SW-1:0] unused_sw;
  assign unused_sw = '0;
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 21,
  parameter logic [7:0]  MFR_CODE = 8'hBF,
  parameter logic [7:0]  DEV_CODE = 8'hC9
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    id_data_o
);
  always_comb begin
    id_data_o = 8'h00;
    if (mode_i == MODE_ID && rd_addr_i[AW-1:1] == '0)
      id_data_o = rd_addr_i[0] ? DEV_CODE : MFR_CODE;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW       = 21,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned BLK_LSB  = 16,
  parameter bit          TOP_BOOT = 1'b1,
  parameter logic [7:0]  MFR_CODE = 8'hBF,
  parameter logic [7:0]  DEV_CODE = 8'hC9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          wp_ni,
  input  logic          op_done_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          op_valid_o,
  output logic [2:0]    op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic [1:0]    mode_o,
  output logic          busy_o,
  output logic          suspended_o,
  output logic [7:0]    id_data_o
);
  cmd_e     cmd;
  op_kind_e kind;
  mode_e    mode;
  logic     busy;

  flash_unlock_seq u_seq (
    .clk_i, .rst_ni, .wr_i,
    .addr_lo_i (addr_i[CMD_AW-1:0]),
    .data_i,
    .busy_i    (busy),
    .cmd_o     (cmd)
  );

  flash_op_ctrl #(.AW(AW), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB), .TOP_BOOT(TOP_BOOT)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_i      (cmd),
    .addr_i, .data_i, .wp_ni, .op_done_i,
    .op_valid_o,
    .op_kind_o  (kind),
    .op_addr_o, .op_data_o,
    .mode_o     (mode),
    .busy_o     (busy),
    .susp_o     (suspended_o)
  );

  flash_id_rom #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .mode_i (mode), .rd_addr_i, .id_data_o
  );

  assign op_kind_o = kind;
  assign mode_o    = mode;
  assign busy_o    = busy;
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, wp_n = 1'b1, done = 1'b0;
  logic [20:0] addr = '0, rd_addr = '0;
  logic [7:0]  data = '0;
  logic        op_valid, busy, susp;
  logic [2:0]  op_kind;
  logic [20:0] op_addr;
  logic [7:0]  op_data, id_data;
  logic [1:0]  mode;

  int checks = 0, errors = 0;
  logic        c_v, c_busy, c_susp;
  logic [2:0]  c_k;
  logic [20:0] c_a;
  logic [7:0]  c_d;
  logic [1:0]  c_m;

  always #5ns clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .wp_ni(wp_n), .op_done_i(done), .rd_addr_i(rd_addr),
    .op_valid_o(op_valid), .op_kind_o(op_kind), .op_addr_o(op_addr), .op_data_o(op_data),
    .mode_o(mode), .busy_o(busy), .suspended_o(susp), .id_data_o(id_data)
  );

  function automatic logic erase_allowed(input logic chip, input logic [20:0] a, input logic wp);
    if (wp) return 1'b1;
    if (chip) return 1'b0;
    return a[20:16] != 5'h1F;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d;
    @(posedge clk); #1;
    wr = 1'b0;
    c_v = op_valid; c_k = op_kind; c_a = op_addr; c_d = op_data;
    c_m = mode; c_busy = busy; c_susp = susp;
  endtask

  task automatic unlock3(input logic [7:0] code);
    logic [8:0] up;
    up = 9'($urandom);
    wr1({up, 12'hAAA}, 8'hAA);
    wr1({~up, 12'h555}, 8'h55);
    wr1({up ^ 9'h5A, 12'hAAA}, code);
  endtask

  task automatic erase6(input logic [20:0] a, input logic [7:0] code);
    unlock3(8'h80);
    wr1(21'h000AAA, 8'hAA);
    wr1(21'h000555, 8'h55);
    wr1(a, code);
  endtask

  task automatic finish_op();
    @(negedge clk); done = 1'b1;
    @(posedge clk); #1; done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("reset op_valid", op_valid, 0);
    chk("reset mode", mode, 0);
    chk("reset busy", busy, 0);
    chk("reset suspended", susp, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4/R5 ID entry and readback
    unlock3(8'h90);
    chk("R4 id mode", c_m, 1);
    rd_addr = 21'd0; #1 chk("R5 mfr code", id_data, 8'hBF);
    rd_addr = 21'd1; #1 chk("R5 dev code", id_data, 8'hC9);
    rd_addr = 21'd2; #1 chk("R5 other addr", id_data, 8'h00);

    // R1 program, R7 ignore while busy
    unlock3(8'hA0);
    wr1(21'h12345, 8'h3C);
    chk("R1 valid", c_v, 1); chk("R1 kind", c_k, 1);
    chk("R1 addr", c_a, 21'h12345); chk("R1 data", c_d, 8'h3C);
    chk("R1 busy", c_busy, 1);
    wr1(21'h0, 8'hF0);
    chk("R7 exit ignored mode", c_m, 1); chk("R7 no op", c_v, 0);
    unlock3(8'h98);
    chk("R7 cfi ignored", c_m, 1);
    finish_op();
    chk("R7 done clears busy", busy, 0);
    wr1(21'h1ABCD, 8'hF0);
    chk("R4 single exit", c_m, 0);
    rd_addr = 21'd0; #1 chk("R5 not id mode", id_data, 8'h00);

    // R2 security-ID program
    unlock3(8'hA5);
    wr1(21'h00021, 8'h77);
    chk("R2 kind", c_k, 2); chk("R2 addr", c_a, 21'h00021); chk("R2 data", c_d, 8'h77);
    finish_op();

    // R4 other modes and third-write exit
    unlock3(8'h88); chk("R4 secid mode", c_m, 3);
    unlock3(8'hF0); chk("R4 seq exit", c_m, 0);

    // R6 aborts
    unlock3(8'h98); chk("R4 cfi mode", c_m, 2);
    wr1(21'h000AAA, 8'hAA); wr1(21'h000556, 8'h55);
    chk("R6 abort mode", c_m, 0); chk("R6 abort no op", c_v, 0);
    unlock3(8'h80); wr1(21'h000AAA, 8'hAA); wr1(21'h000555, 8'h54);
    chk("R6 erase abort", c_v, 0);
    erase6(21'h04000, 8'h20);
    chk("R6 bad erase code", c_v, 0); chk("R6 not busy", c_busy, 0);
    wr1(21'h00000, 8'h00);
    chk("R6 after abort no op", c_v, 0);
    unlock3(8'hA0); wr1(21'h00010, 8'h11);
    chk("R6 seq recovers", c_k, 1);
    finish_op();

    // R3/R8 erases
    wp_n = 1'b1;
    erase6(21'h000AAA, 8'h10);
    chk("R3 chip kind", c_k, 5); chk("R3 chip valid", c_v, 1);
    wr1(21'h0, 8'hB0);
    chk("R9 chip no suspend", c_v, 0); chk("R9 chip still busy", c_busy, 1);
    finish_op();
    wp_n = 1'b0;
    erase6(21'h000AAA, 8'h10);
    chk("R8 chip dropped", c_v, 0); chk("R8 chip not busy", c_busy, 0);
    erase6(21'h1F3000, 8'h50);
    chk("R8 boot sector dropped", c_v, 0);
    erase6(21'h1F0000, 8'h30);
    chk("R8 boot block dropped", c_v, 0);
    erase6(21'h0E0000, 8'h30);
    chk("R3 block kind", c_k, 4); chk("R3 block addr", c_a, 21'h0E0000);
    finish_op();

    // R9/R10 suspend flow
    wp_n = 1'b1;
    erase6(21'h1F3000, 8'h50);
    chk("R3 sector kind", c_k, 3); chk("R3 sector addr", c_a, 21'h1F3000);
    wr1(21'h0, 8'hB0);
    chk("R9 suspend op", c_k, 6); chk("R9 suspended", c_susp, 1); chk("R9 not busy", c_busy, 0);
    unlock3(8'hA0); wr1(21'h1F3FFF, 8'h01);
    chk("R10 region prog dropped", c_v, 0); chk("R10 still idle", c_busy, 0);
    unlock3(8'hA0); wr1(21'h1F4000, 8'h02);
    chk("R10 other prog", c_k, 1); chk("R10 other addr", c_a, 21'h1F4000);
    chk("R10 busy", c_busy, 1);
    finish_op();
    chk("R10 back to suspend", susp, 1); chk("R10 not busy", busy, 0);
    wr1(21'h05555, 8'h30);
    chk("R9 resume op", c_k, 7); chk("R9 resume addr", c_a, 21'h1F3000);
    chk("R9 resumed busy", c_busy, 1); chk("R9 not suspended", c_susp, 0);
    finish_op();
    wr1(21'h0, 8'hB0);
    chk("R9 idle suspend ignored", c_v, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [20:0] a; logic [7:0] d; int sel; logic w;
      a = 21'($urandom); d = 8'($urandom); sel = $urandom % 4; w = 1'($urandom);
      if (sel == 0) begin
        unlock3(8'hA0); wr1(a, d);
        chk("R1 rand kind", c_k, 1); chk("R1 rand addr", c_a, a); chk("R1 rand data", c_d, d);
        finish_op();
      end else if (sel == 1 || sel == 2) begin
        if ($urandom % 2 == 1) a[20:16] = 5'h1F;
        wp_n = w;
        erase6(a, sel == 1 ? 8'h50 : 8'h30);
        chk("R8 rand issue", c_v, erase_allowed(1'b0, a, w));
        if (c_v) begin
          chk("R3 rand kind", c_k, sel == 1 ? 3 : 4);
          chk("R3 rand addr", c_a, a);
          finish_op();
        end
      end else begin
        if (d == 8'hAA || d == 8'hF0 || d == 8'hB0 || d == 8'h30) d = 8'h00;
        wr1(a, d);
        chk("R6 stray no op", c_v, 0); chk("R6 stray mode", c_m, 0);
      end
    end
    wp_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule